// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

The block collects interrupt requests from shared hardware lines, per-CPU private lines and software commands. For each CPU it reports the single most urgent request that is pending, enabled and aimed at that CPU. Per source it keeps an enable bit, a trigger mode, an 8-bit priority and an 8-bit CPU target mask. Software sets and reads this state over a simple 32-bit register bus. Each access carries a CPU number, which selects that CPU's private copy of source IDs 0 to 31.

IDs 0 to 15 are software interrupts. They become pending only through the command register. IDs 16 to 31 are private hardware lines, one set per CPU. IDs 32 and up are shared lines, routed by their target byte. A CPU's handler writes the ID it is serving to the acknowledge register, which clears that pending bit.

Top module: `irq_distributor`

## Requirements
- R1: Enable state changes only on one bits. A one written at byte address 0x100+(id/32)*4 enables the source at bit id%32. A one written at 0x180+(id/32)*4 disables it. Zero bits change nothing. A read at either address returns the current enable bits.
- R2: For IDs 0 to 31, the enable bits and pending bits exist once per CPU, and `bus_cpu` selects the copy that an access touches. Word 0 of the pending view (0x200) and word 0 of the enable view show only the requesting CPU's copy.
- R3: Trigger mode takes two bits per source at 0xC00+(id/16)*4, bits [2*(id%16)+1 : 2*(id%16)]. The upper bit set means rising edge and clear means level. The lower bit reads as 0. For IDs 0 to 15 the field is fixed: writes have no effect and it reads as 00.
- R4: Priority bytes sit at 0x400+(id/4)*4 and target bytes at 0x800+(id/4)*4, with the source's byte at bits [8*(id%4)+7 : 8*(id%4)]. Target bit c selects CPU c. Both read back what was written.
- R5: The read-only register at 0x004 returns NUM_SRC/32-1 in bits [4:0], so the source count is (value+1)*32, limited to at most 1020 usable sources. All other bits read 0.
- R6: Bit 0 of the control register at 0x000 enables forwarding. While it is 0, `irq_valid` is 0 for every CPU. Pending state still accumulates.
- R7: A write to 0x F00 with target mask bits [23:16] and ID bits [3:0] sets that ID pending in the private copy of each CPU whose mask bit is 1.
- R8: A source in edge mode becomes pending on a 0-to-1 change of its input. A source in level mode becomes pending whenever its input is high. In both modes the pending bit then stays set until it is acknowledged. An acknowledge has no lasting effect while a level input is still high.
- R9: For CPU c, the output shows the highest-priority request among sources that are pending, enabled and targeted at c. A shared source is targeted at c when target bit c is set. A private source is always targeted at its own CPU. The lowest priority value wins, and on a tie the lowest ID wins. `irq_id` is valid only while `irq_valid` is 1.
- R10: After reset, all enables, pending bits, trigger modes, priorities, targets and the control bit are 0, and `irq_valid` is 0.
- R11: Writing an ID in bits [9:0] to 0x00C clears that source's pending bit. For IDs 0 to 31 it clears only the requesting CPU's copy.
- R12: `bus_rvalid` pulses, and `bus_rdata` holds the read result, one cycle after a read request. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte address bits [11:2]) |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPUW | Number of the requesting CPU |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| spi_in | input | NUM_SRC-32 | Shared interrupt lines, bit k is ID 32+k |
| ppi_in | input | NUM_CPU*16 | Private lines, bit c*16+k is ID 16+k of CPU c |
| irq_valid | output | NUM_CPU | A request is shown for CPU c |
| irq_id | output | NUM_CPU*IDW | ID shown for CPU c at bits [c*IDW +: IDW] |

## Verification
Wrong internal state shows up as a wrong `irq_valid` or `irq_id` within two cycles of the stimulus that set it up. It can also show up on the read value returned one cycle after a read of the enable, pending or configuration views. Typical symptoms are a lost pending bit, a CPU seeing another CPU's private copy, or a tie resolved toward the higher ID. The bench therefore checks the outputs after each event: edge pulses, a held level, acknowledges, software commands aimed at chosen CPUs, and forwarding turned off. It also reads the state back through the bus.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam logic [9:0] W_CTRL = 10'h000;
  localparam logic [9:0] W_TYPE = 10'h001;
  localparam logic [9:0] W_ACK  = 10'h003;
  localparam logic [9:0] W_SGI  = 10'h3C0;
  localparam logic [4:0] RG_ENSET = 5'b00010;
  localparam logic [4:0] RG_ENCLR = 5'b00011;
  localparam logic [4:0] RG_PEND  = 5'b00100;
  localparam logic [1:0] RG_PRIO  = 2'b01;
  localparam logic [1:0] RG_TGT   = 2'b10;
  localparam logic [3:0] RG_CFG   = 4'hC;
  typedef logic [7:0] prio_t;
endpackage

// File: rtl/irq_dist_pend.sv
module irq_dist_pend #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_in,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] in_q;
  logic [N-1:0] hw_set;
  logic [N-1:0] pend_n;

  always_comb begin
    hw_set = (edge_mode & lvl_in & ~in_q) | (~edge_mode & lvl_in);
    pend_n = hw_set | sw_set | (pend & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= '0;
      pend <= '0;
    end else begin
      in_q <= lvl_in;
      pend <= pend_n;
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0)); // R8
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDW     = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fwd,
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC-1:0][7:0]   prio,
  output logic                      valid_q,
  output logic [IDW-1:0]            id_q
);
  logic           best_v;
  prio_t          best_p;
  logic [IDW-1:0] best_id;
  logic           valid_n;

  always_comb begin
    best_v  = 1'b0;
    best_p  = '1;
    best_id = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!best_v || prio[i] < best_p)) begin
        best_v  = 1'b1;
        best_p  = prio[i];
        best_id = IDW'(i);
      end
    end
    valid_n = fwd & best_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      id_q    <= '0;
    end else begin
      valid_q <= valid_n;
      if (valid_n) id_q <= best_id;
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 8,
  parameter int CPUW    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int IDW     = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_wr,
  input  logic [11:2]            bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic [CPUW-1:0]        bus_cpu,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  input  logic [NUM_SRC-33:0]    spi_in,
  input  logic [NUM_CPU*16-1:0]  ppi_in,
  output logic [NUM_CPU-1:0]     irq_valid,
  output logic [NUM_CPU*IDW-1:0] irq_id
);
  localparam int NSH   = NUM_SRC - 32;
  localparam int NWORD = NUM_SRC / 32;
  localparam logic [4:0] TYPE_VAL = 5'(NWORD - 1);

  logic                           ctrl_fwd, ctrl_n;
  logic [NSH-1:0]                 en_sh, en_sh_n;
  logic [NUM_CPU-1:0][31:0]       en_bk, en_bk_n;
  logic [NUM_SRC-1:16]            cfg_edge, cfg_n;
  logic [NUM_SRC-1:0][7:0]        prio, prio_n;
  logic [NUM_SRC-1:0][7:0]        tgt, tgt_n;
  logic [NSH-1:0]                 pend_sh, ack_sh;
  logic [NUM_CPU-1:0][31:0]       pend_bk, ack_bk;
  logic [NUM_CPU-1:0][15:0]       sgi_hit;
  logic [31:0]                    rdata_n;
  logic                           wr, rd, cpu_ok;

  assign wr     = bus_req & bus_wr;
  assign rd     = bus_req & ~bus_wr;
  assign cpu_ok = int'(bus_cpu) < NUM_CPU;

  // register writes
  always_comb begin
    ctrl_n  = ctrl_fwd;
    en_sh_n = en_sh;
    en_bk_n = en_bk;
    cfg_n   = cfg_edge;
    prio_n  = prio;
    tgt_n   = tgt;
    if (wr && bus_addr == W_CTRL) ctrl_n = bus_wdata[0];
    if (wr && (bus_addr[11:7] == RG_ENSET || bus_addr[11:7] == RG_ENCLR)) begin
      for (int w = 0; w < NWORD; w++) begin
        if (bus_addr[6:2] == 5'(w)) begin
          if (w == 0) begin
            if (cpu_ok) begin
              if (bus_addr[7]) en_bk_n[bus_cpu] = en_bk[bus_cpu] & ~bus_wdata;
              else             en_bk_n[bus_cpu] = en_bk[bus_cpu] | bus_wdata;
            end
          end else begin
            if (bus_addr[7]) en_sh_n[(w-1)*32 +: 32] = en_sh[(w-1)*32 +: 32] & ~bus_wdata;
            else             en_sh_n[(w-1)*32 +: 32] = en_sh[(w-1)*32 +: 32] | bus_wdata;
          end
        end
      end
    end
    if (wr && bus_addr[11:10] == RG_PRIO)
      for (int w = 0; w < NUM_SRC/4; w++)
        if (bus_addr[9:2] == 8'(w)) prio_n[w*4 +: 4] = bus_wdata;
    if (wr && bus_addr[11:10] == RG_TGT)
      for (int w = 0; w < NUM_SRC/4; w++)
        if (bus_addr[9:2] == 8'(w)) tgt_n[w*4 +: 4] = bus_wdata;
    if (wr && bus_addr[11:8] == RG_CFG)
      for (int i = 16; i < NUM_SRC; i++)
        if (bus_addr[7:2] == 6'(i/16)) cfg_n[i] = bus_wdata[2*(i%16)+1];
  end

  // acknowledge and software-interrupt strobes
  always_comb begin
    for (int i = 0; i < NSH; i++)
      ack_sh[i] = wr && bus_addr == W_ACK && bus_wdata[9:0] == 10'(i+32);
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int j = 0; j < 32; j++)
        ack_bk[c][j] = wr && bus_addr == W_ACK && bus_cpu == CPUW'(c) &&
                       bus_wdata[9:0] == 10'(j);
      for (int j = 0; j < 16; j++)
        sgi_hit[c][j] = wr && bus_addr == W_SGI && bus_wdata[16+c] &&
                        bus_wdata[3:0] == 4'(j);
    end
  end

  // read mux
  always_comb begin
    rdata_n = '0;
    if (bus_addr == W_CTRL) rdata_n = {31'b0, ctrl_fwd};
    else if (bus_addr == W_TYPE) rdata_n = {27'b0, TYPE_VAL};
    else if (bus_addr[11:8] == 4'h1 || bus_addr[11:7] == RG_PEND) begin
      for (int w = 0; w < NWORD; w++) begin
        if (bus_addr[6:2] == 5'(w)) begin
          if (w == 0) begin
            if (cpu_ok) rdata_n = bus_addr[9] ? pend_bk[bus_cpu] : en_bk[bus_cpu];
          end else begin
            rdata_n = bus_addr[9] ? pend_sh[(w-1)*32 +: 32] : en_sh[(w-1)*32 +: 32];
          end
        end
      end
    end else if (bus_addr[11:10] == RG_PRIO) begin
      for (int w = 0; w < NUM_SRC/4; w++)
        if (bus_addr[9:2] == 8'(w)) rdata_n = prio[w*4 +: 4];
    end else if (bus_addr[11:10] == RG_TGT) begin
      for (int w = 0; w < NUM_SRC/4; w++)
        if (bus_addr[9:2] == 8'(w)) rdata_n = tgt[w*4 +: 4];
    end else if (bus_addr[11:8] == RG_CFG) begin
      for (int i = 16; i < NUM_SRC; i++)
        if (bus_addr[7:2] == 6'(i/16)) rdata_n[2*(i%16)+1] = cfg_edge[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_fwd   <= 1'b0;
      en_sh      <= '0;
      en_bk      <= '0;
      cfg_edge   <= '0;
      prio       <= '0;
      tgt        <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (wr) begin
        ctrl_fwd <= ctrl_n;
        en_sh    <= en_sh_n;
        en_bk    <= en_bk_n;
        cfg_edge <= cfg_n;
        prio     <= prio_n;
        tgt      <= tgt_n;
      end
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rdata_n;
    end
  end

  irq_dist_pend #(.N(NSH)) u_pend_sh (
    .clk(clk), .rst_n(rst_n), .lvl_in(spi_in), .edge_mode(cfg_edge[NUM_SRC-1:32]),
    .sw_set('0), .clr(ack_sh), .pend(pend_sh));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] cand;
    logic [IDW-1:0]     id_c;

    irq_dist_pend #(.N(32)) u_pend_bk (
      .clk(clk), .rst_n(rst_n), .lvl_in({ppi_in[c*16 +: 16], 16'b0}),
      .edge_mode({cfg_edge[31:16], 16'b0}), .sw_set({16'b0, sgi_hit[c]}),
      .clr(ack_bk[c]), .pend(pend_bk[c]));

    always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (i < 32) cand[i] = en_bk[c][i] & pend_bk[c][i];
        else        cand[i] = en_sh[i-32] & pend_sh[i-32] & tgt[i][c];
      end
    end

    irq_dist_arb #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_arb (
      .clk(clk), .rst_n(rst_n), .fwd(ctrl_fwd), .cand(cand), .prio(prio),
      .valid_q(irq_valid[c]), .id_q(id_c));
    assign irq_id[c*IDW +: IDW] = id_c;

    AST_SGI_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == W_SGI && bus_wdata[16+c])
      |=> pend_bk[c][$past(bus_wdata[3:0])]); // R7
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == 10'h041)
    |=> ((en_sh[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R1
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == 10'h061)
    |=> ((en_sh[31:0] & $past(bus_wdata)) == '0)); // R1
  AST_FWD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_fwd |=> (irq_valid == '0)); // R6
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvalid); // R12
endmodule

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
  localparam int NS = 64;
  localparam int NC = 8;
  localparam int IW = 6;

  logic            clk, rst_n;
  logic            bus_req, bus_wr;
  logic [11:2]     bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [2:0]      bus_cpu;
  logic            bus_rvalid;
  logic [NS-33:0]  spi_in;
  logic [NC*16-1:0] ppi_in;
  logic [NC-1:0]   irq_valid;
  logic [NC*IW-1:0] irq_id;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  irq_distributor dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .spi_in(spi_in),
    .ppi_in(ppi_in), .irq_valid(irq_valid), .irq_id(irq_id));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] c);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a[11:2]; bus_wdata = d; bus_cpu = c;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] c, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a[11:2]; bus_cpu = c;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input int c, input logic v, input int id, input string t);
    @(negedge clk);
    total++;
    if (irq_valid[c] !== v || (v && irq_id[c*IW +: IW] !== IW'(id))) begin
      bad++;
      $display("FAIL %s cpu%0d: got valid=%0b id=%0d, expected valid=%0b id=%0d",
               t, c, irq_valid[c], irq_id[c*IW +: IW], v, id);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R12: unexpected read data %h, expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: got %h, expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_cpu = '0; spi_in = '0; ppi_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R10 reset state, R5 type
    chk_irq(0, 1'b0, 0, "R10 reset irq");
    rd(12'h000, 0, 32'h0, "R10 ctrl reset");
    rd(12'h004, 0, 32'h1, "R5 type value");
    rd(12'h104, 0, 32'h0, "R10 enable reset");
    rd(12'h420, 0, 32'h0, "R10 prio reset");
    rd(12'h820, 0, 32'h0, "R10 target reset");

    // R1 set/clear semantics
    wr(12'h104, 32'h5, 0);
    rd(12'h104, 0, 32'h5, "R1 set read");
    rd(12'h184, 0, 32'h5, "R1 clear view read");
    wr(12'h184, 32'h1, 0);
    rd(12'h104, 0, 32'h4, "R1 clear bit");
    wr(12'h104, 32'h0, 0);
    rd(12'h104, 0, 32'h4, "R1 zero write");

    // R4 priority/target layout
    wr(12'h420, 32'h40302010, 0);
    wr(12'h820, 32'h01010101, 0);
    rd(12'h420, 0, 32'h40302010, "R4 prio read");
    rd(12'h820, 0, 32'h01010101, "R4 target read");

    // R3 trigger config
    wr(12'hC08, 32'h0000000B, 0);
    rd(12'hC08, 0, 32'h0000000A, "R3 cfg upper bits");
    wr(12'hC00, 32'hFFFFFFFF, 0);
    rd(12'hC00, 0, 32'h0, "R3 sgi cfg fixed");

    // R8 edge, R9 routing
    wr(12'h000, 32'h1, 0);
    wr(12'h104, 32'h7, 0);
    @(negedge clk); spi_in[0] = 1'b1;
    @(negedge clk); spi_in[0] = 1'b0;
    idle(2);
    chk_irq(0, 1'b1, 32, "R8 edge pend");
    chk_irq(1, 1'b0, 0, "R9 not targeted");
    rd(12'h204, 0, 32'h1, "R8 pending view");

    // R9 priority, R11 ack, R8 level
    @(negedge clk); spi_in[2] = 1'b1;
    idle(2);
    chk_irq(0, 1'b1, 32, "R9 lower value wins");
    wr(12'h00C, 32'd32, 0);
    idle(2);
    chk_irq(0, 1'b1, 34, "R11 ack reveals next");
    wr(12'h00C, 32'd34, 0);
    idle(2);
    chk_irq(0, 1'b1, 34, "R8 level ack while high");
    @(negedge clk); spi_in[2] = 1'b0;
    idle(2);
    chk_irq(0, 1'b1, 34, "R8 level latched after drop");
    wr(12'h00C, 32'd34, 0);
    idle(2);
    chk_irq(0, 1'b0, 0, "R11 ack clears");

    // R9 tie
    wr(12'h420, 32'h00305050, 0);
    @(negedge clk); spi_in[1:0] = 2'b11;
    @(negedge clk); spi_in[1:0] = 2'b00;
    idle(2);
    chk_irq(0, 1'b1, 32, "R9 tie lower id");
    wr(12'h00C, 32'd32, 0);
    idle(2);
    chk_irq(0, 1'b1, 33, "R9 tie second");
    wr(12'h00C, 32'd33, 0);
    idle(2);
    chk_irq(0, 1'b0, 0, "R11 all acked");

    // R6 forwarding gate
    wr(12'h000, 32'h0, 0);
    @(negedge clk); spi_in[0] = 1'b1;
    @(negedge clk); spi_in[0] = 1'b0;
    idle(2);
    chk_irq(0, 1'b0, 0, "R6 forwarding off");
    rd(12'h204, 0, 32'h1, "R6 pending kept");
    wr(12'h000, 32'h1, 0);
    idle(2);
    chk_irq(0, 1'b1, 32, "R6 forwarding on");
    wr(12'h00C, 32'd32, 0);

    // R7 software interrupt, R2 banking
    wr(12'h100, 32'h8, 1);
    wr(12'hF00, 32'h00060003, 0);
    idle(2);
    chk_irq(1, 1'b1, 3, "R7 sgi cpu1");
    chk_irq(2, 1'b0, 0, "R2 cpu2 not enabled");
    chk_irq(0, 1'b0, 0, "R7 cpu0 untargeted");
    rd(12'h200, 2, 32'h8, "R7 pend cpu2");
    rd(12'h200, 0, 32'h0, "R2 pend cpu0");
    rd(12'h180, 1, 32'h8, "R2 enable cpu1");
    rd(12'h100, 0, 32'h0, "R2 enable cpu0");
    wr(12'h00C, 32'd3, 1);
    idle(2);
    chk_irq(1, 1'b0, 0, "R11 banked ack");
    rd(12'h200, 2, 32'h8, "R11 other bank kept");

    // R2 private line
    wr(12'h100, 32'h00010000, 1);
    @(negedge clk); ppi_in[16] = 1'b1;
    idle(2);
    chk_irq(1, 1'b1, 16, "R2 private line");
    chk_irq(0, 1'b0, 0, "R2 private isolated");
    @(negedge clk); ppi_in[16] = 1'b0;
    wr(12'h00C, 32'd16, 1);
    idle(2);
    chk_irq(1, 1'b0, 0, "R11 private ack");

    // R12 unmapped
    rd(12'h300, 0, 32'h0, "R12 unmapped");
    idle(4);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R12: got %0d reads missing, expected 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule